// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Sequencer

This block is the host-side engine that keeps an asynchronous DRAM alive. When reset is released it keeps both strobes idle for a programmable power-up pause. It then runs a fixed number of warm-up refresh cycles, with CAS asserted before RAS, on its own authority, and only after that does it raise `init_done_o`. From then on an interval timer adds one owed refresh every `INTERVAL_CYC` clocks. The block asks the access sequencer for the memory bus with `req_o`. On `grant_i` it drives the RAS/CAS/WE strobe overrides through one refresh cycle. If it owes more than one refresh, it runs the owed cycles back to back before it lets the bus go.

Owed refreshes build up in a saturating backlog counter while the bus is withheld. The cap on that counter is a parameter. A sleep input takes the memory into self-refresh. The block enters with a CAS-first strobe sequence, keeps RAS low for at least a minimum time, and on exit holds RAS high for a recovery time. A parameter can switch the periodic cycles to row-address refresh. In that mode CAS stays high and an internal row counter supplies the address. The warm-up and self-refresh sequences stay CAS-first in either mode. All times are counted in clock cycles.

Top module: `refresh_sched`

## Requirements
- R1: After reset is released, RAS and CAS both stay high for at least `PAUSE_CYC` clock cycles.
- R2: After the pause, exactly `WARMUP` CAS-first refresh cycles run without any grant. `init_done_o` then rises and never falls again. `req_o` stays low while `init_done_o` is low.
- R3: In every CAS-first cycle, CAS goes low `CSR_CYC` cycles before RAS falls and stays low for the whole RAS-low time. CAS rises in the same cycle as RAS. `we_n_o` is always high.
- R4: After initialization, one refresh becomes owed every `INTERVAL_CYC` cycles. With the grant held high, successive periodic RAS falls are exactly `INTERVAL_CYC` cycles apart.
- R5: After initialization, no refresh cycle starts unless `grant_i` was high. `req_o` stays high from the request until the last owed cycle ends and then drops. `busy_o` is low while the block waits for a grant.
- R6: The backlog saturates at `BACKLOG_MAX` owed refreshes. Once granted, the owed cycles run back to back, with RAS falls `CSR_CYC+RAS_CYC+RP_CYC` cycles apart.
- R7: A high `sleep_i` while the block is idle leads to a request and then a CAS-first entry into self-refresh. `self_active_o` is high during self-refresh, and RAS stays low for at least `SELF_MIN_CYC` cycles even if `sleep_i` drops earlier.
- R8: On leaving self-refresh, RAS stays high for at least `SELF_EXIT_CYC` cycles. The backlog is discarded and the interval restarts, so the next refresh comes more than `INTERVAL_CYC` cycles after RAS rises.
- R9: With `ROW_ONLY=1`, periodic cycles keep CAS high, assert `row_drv_o` and present `row_o`. `row_o` starts at 0 and goes up by one after each row cycle. The warm-up cycles stay CAS-first.
- R10: During reset, RAS and CAS are high and `req_o`, `busy_o` and `init_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant_i | input | 1 | Bus granted by the access sequencer |
| sleep_i | input | 1 | Request to enter (high) or leave (low) self-refresh |
| req_o | output | 1 | Bus request, held until the owed work is done |
| busy_o | output | 1 | A strobe sequence is in progress |
| init_done_o | output | 1 | Pause and warm-up complete; accesses allowed |
| self_active_o | output | 1 | Memory held in self-refresh |
| ras_n_o | output | 1 | RAS override, active low |
| cas_n_o | output | 1 | CAS override, active low |
| we_n_o | output | 1 | WE override, held high |
| row_drv_o | output | 1 | `row_o` must be driven on the address pins |
| row_o | output | ROW_W | Row address for row-address refresh |

## Verification
The bench holds the grant low during warm-up. A design that waited for a grant there would hang before `init_done_o`, and one that ran the wrong number of warm-up cycles shows a wrong fall count. It then withholds the grant for four refresh intervals. A backlog that does not saturate would emit four cycles instead of three, and one that leaks past the grant shows RAS activity during the wait. It drops `sleep_i` long before the minimum self-refresh time. A design that released early would show a short RAS-low pulse, and one that kept the stale backlog would refresh right after the exit instead of a full interval later. A second instance in row mode catches CAS going low or a wrong row address on periodic cycles.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_REQ,
        ST_LEAD,
        ST_STROBE,
        ST_PRECH,
        ST_SELF,
        ST_SEXIT
    } rs_state_e;

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfs_ticker.sv
module rfs_ticker #(
    parameter int INTERVAL_CYC = 1950,
    parameter int BACKLOG_MAX  = 4,
    parameter int PEND_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clear_i,
    input  logic              take_i,
    output logic [PEND_W-1:0] pend_o
);
    localparam int IW = $clog2(INTERVAL_CYC + 1);
    localparam logic [IW-1:0]     TICK_LAST = IW'(INTERVAL_CYC - 1);
    localparam logic [PEND_W-1:0] PEND_CAP  = PEND_W'(BACKLOG_MAX);

    typedef struct packed {
        logic [IW-1:0]     cnt;
        logic [PEND_W-1:0] pend;
    } tk_t;

    tk_t  d, q;
    logic tick;

    always_comb begin
        d    = q;
        tick = run_i && (q.cnt == TICK_LAST);
        if (clear_i) begin
            d = '0;
        end else begin
            if (run_i) d.cnt = tick ? '0 : q.cnt + 1'b1;
            // a tick arriving at the cap is dropped; tick plus take cancel out
            if (tick && !take_i && (q.pend != PEND_CAP)) d.pend = q.pend + 1'b1;
            else if (!tick && take_i)                   d.pend = q.pend - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o = q.pend;
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = inc_i ? row_q + 1'b1 : row_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row_o = row_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int PAUSE_CYC     = 12500,
    parameter int WARMUP        = 8,
    parameter int INTERVAL_CYC  = 1950,
    parameter int BACKLOG_MAX   = 4,
    parameter int CSR_CYC       = 1,
    parameter int RAS_CYC       = 8,
    parameter int RP_CYC        = 5,
    parameter int SELF_MIN_CYC  = 12500,
    parameter int SELF_EXIT_CYC = 12,
    parameter int ROW_ONLY      = 0,
    parameter int ROW_W         = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_i,
    input  logic             sleep_i,
    output logic             req_o,
    output logic             busy_o,
    output logic             init_done_o,
    output logic             self_active_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic             we_n_o,
    output logic             row_drv_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int MAXC = max_of(max_of(max_of(PAUSE_CYC, SELF_MIN_CYC),
                                        max_of(RAS_CYC, RP_CYC)),
                                 max_of(CSR_CYC, SELF_EXIT_CYC));
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam int WARM_W = $clog2(WARMUP + 1);
    localparam int PEND_W = $clog2(BACKLOG_MAX + 1);
    localparam bit ROW_MODE = (ROW_ONLY != 0);

    localparam logic [CNT_W-1:0]  PAUSE_LAST = CNT_W'(PAUSE_CYC - 1);
    localparam logic [CNT_W-1:0]  CSR_LAST   = CNT_W'(CSR_CYC - 1);
    localparam logic [CNT_W-1:0]  RAS_LAST   = CNT_W'(RAS_CYC - 1);
    localparam logic [CNT_W-1:0]  RP_LAST    = CNT_W'(RP_CYC - 1);
    localparam logic [CNT_W-1:0]  SELF_LAST  = CNT_W'(SELF_MIN_CYC - 1);
    localparam logic [CNT_W-1:0]  SEXIT_LAST = CNT_W'(SELF_EXIT_CYC - 1);
    localparam logic [WARM_W-1:0] WARM_LAST  = WARM_W'(WARMUP - 1);

    typedef struct packed {
        rs_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [WARM_W-1:0] warm;
        logic              done;   // pause and warm-up finished
        logic              cbr;    // current cycle is CAS-first
        logic              slp;    // current request is a self-refresh entry
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_PAUSE, cnt: '0, warm: '0,
                                 done: 1'b0, cbr: 1'b0, slp: 1'b0};

    ctl_t              d, q;
    logic              take;
    logic              row_inc;
    logic [PEND_W-1:0] pend;

    rfs_ticker #(
        .INTERVAL_CYC(INTERVAL_CYC),
        .BACKLOG_MAX (BACKLOG_MAX),
        .PEND_W      (PEND_W)
    ) u_ticker (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.done && (q.st != ST_SELF) && (q.st != ST_SEXIT)),
        .clear_i(q.st == ST_SEXIT),
        .take_i (take),
        .pend_o (pend)
    );

    rfs_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk  (clk),
        .rst_n(rst_n),
        .inc_i(row_inc),
        .row_o(row_o)
    );

    always_comb begin
        d       = q;
        take    = 1'b0;
        row_inc = 1'b0;
        case (q.st)
            ST_PAUSE: begin
                if (q.cnt == PAUSE_LAST) begin
                    d.st  = ST_LEAD;
                    d.cnt = '0;
                    d.cbr = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_IDLE: begin
                if (pend != '0) begin
                    d.st  = ST_REQ;
                    d.slp = 1'b0;
                end else if (sleep_i) begin
                    d.st  = ST_REQ;
                    d.slp = 1'b1;
                end
            end
            ST_REQ: begin
                if (grant_i) begin
                    d.st  = ST_LEAD;
                    d.cnt = '0;
                    d.cbr = q.slp || !ROW_MODE;
                end
            end
            ST_LEAD: begin
                if (q.cnt == CSR_LAST) begin
                    d.st  = q.slp ? ST_SELF : ST_STROBE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_STROBE: begin
                if (q.cnt == RAS_LAST) begin
                    d.st    = ST_PRECH;
                    d.cnt   = '0;
                    row_inc = !q.cbr;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_PRECH: begin
                if (q.cnt == RP_LAST) begin
                    d.cnt = '0;
                    if (!q.done) begin
                        if (q.warm == WARM_LAST) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.warm = q.warm + 1'b1;
                            d.st   = ST_LEAD;
                            d.cbr  = 1'b1;
                        end
                    end else begin
                        take = 1'b1;
                        if (pend > PEND_W'(1)) begin
                            d.st  = ST_LEAD;
                            d.cbr = !ROW_MODE;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SELF: begin
                if (q.cnt == SELF_LAST) begin
                    if (!sleep_i) begin
                        d.st  = ST_SEXIT;
                        d.cnt = '0;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SEXIT: begin
                if (q.cnt == SEXIT_LAST) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                    d.slp = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign ras_n_o       = !((q.st == ST_STROBE) || (q.st == ST_SELF));
    assign cas_n_o       = !((q.st == ST_SELF) ||
                             (q.cbr && ((q.st == ST_LEAD) || (q.st == ST_STROBE))));
    assign we_n_o        = 1'b1;
    assign row_drv_o     = !q.cbr && ((q.st == ST_LEAD) || (q.st == ST_STROBE));
    assign busy_o        = !((q.st == ST_PAUSE) || (q.st == ST_IDLE) || (q.st == ST_REQ));
    assign req_o         = q.done && (q.st != ST_IDLE);
    assign init_done_o   = q.done;
    assign self_active_o = (q.st == ST_SELF);
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic grant_i,
    input logic req_o,
    input logic busy_o,
    input logic init_done_o,
    input logic self_active_o,
    input logic ras_n_o,
    input logic cas_n_o
);
    // R3
    cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o));

    // R3
    cas_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n_o) |-> ras_n_o);

    // R5
    grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && init_done_o) |-> $past(grant_i));

    // R2
    no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done_o |-> !req_o);

    // R2
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);

    // R8
    self_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n_o) && $past(self_active_o)) |=> ras_n_o);
endmodule

bind refresh_sched refresh_sched_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant_i      (grant_i),
    .req_o        (req_o),
    .busy_o       (busy_o),
    .init_done_o  (init_done_o),
    .self_active_o(self_active_o),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n_o)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
    localparam int PAUSE    = 50;
    localparam int WARM     = 8;
    localparam int INTERVAL = 100;
    localparam int BACKLOG  = 3;
    localparam int CSR      = 1;
    localparam int RASC     = 4;
    localparam int RP       = 3;
    localparam int SELFMIN  = 40;
    localparam int SEXIT    = 5;
    localparam int RW       = 11;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, grant, sleep;
    logic m_req, m_busy, m_init, m_self, m_ras, m_cas, m_we, m_rdrv;
    logic [RW-1:0] m_row;
    logic r_req, r_busy, r_init, r_self, r_ras, r_cas, r_we, r_rdrv;
    logic [RW-1:0] r_row;

    refresh_sched #(
        .PAUSE_CYC(PAUSE), .WARMUP(WARM), .INTERVAL_CYC(INTERVAL), .BACKLOG_MAX(BACKLOG),
        .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RP), .SELF_MIN_CYC(SELFMIN),
        .SELF_EXIT_CYC(SEXIT), .ROW_ONLY(0), .ROW_W(RW)
    ) u_refresh_sched (
        .clk(clk), .rst_n(rst_n), .grant_i(grant), .sleep_i(sleep),
        .req_o(m_req), .busy_o(m_busy), .init_done_o(m_init), .self_active_o(m_self),
        .ras_n_o(m_ras), .cas_n_o(m_cas), .we_n_o(m_we), .row_drv_o(m_rdrv), .row_o(m_row)
    );

    refresh_sched #(
        .PAUSE_CYC(PAUSE), .WARMUP(WARM), .INTERVAL_CYC(INTERVAL), .BACKLOG_MAX(BACKLOG),
        .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RP), .SELF_MIN_CYC(SELFMIN),
        .SELF_EXIT_CYC(SEXIT), .ROW_ONLY(1), .ROW_W(RW)
    ) u_refresh_sched_row (
        .clk(clk), .rst_n(rst_n), .grant_i(1'b1), .sleep_i(1'b0),
        .req_o(r_req), .busy_o(r_busy), .init_done_o(r_init), .self_active_o(r_self),
        .ras_n_o(r_ras), .cas_n_o(r_cas), .we_n_o(r_we), .row_drv_o(r_rdrv), .row_o(r_row)
    );

    typedef struct {
        bit cbr;
        int row;
    } exp_t;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   finished = 0;

    bit   mq[$];
    exp_t rq[$];
    int   fall_t[$];
    int   fall_cnt = 0;
    int   r_fall_cnt = 0;
    int   first_cas_cyc = -1;
    int   low_len = 0;
    int   last_low_len = 0;
    int   last_rise_cyc = 0;
    bit   req_pre_init = 0;
    bit   we_low = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, rprev_ras = 1'b1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver side: queue expected refresh cycles
    task automatic push_main(input int n);
        for (int i = 0; i < n; i++) mq.push_back(1'b1);
    endtask

    task automatic wait_falls(input int n);
        int target;
        target = fall_cnt + n;
        while (fall_cnt < target) @(negedge clk);
    endtask

    // monitor for the CAS-first instance
    always begin
        @(posedge clk);
        #2;
        cyc++;
        if (rst_n) begin
            if (!m_init && m_req) req_pre_init = 1;
            if (!m_we) we_low = 1;
            if (first_cas_cyc < 0 && !m_cas) first_cas_cyc = cyc;
            if (prev_ras && !m_ras) begin
                fall_cnt++;
                fall_t.push_back(cyc);
                if (mq.size() == 0) begin
                    check(0, "R5 unexpected refresh cycle", 1, 0);
                end else begin
                    bit e;
                    e = mq.pop_front();
                    check((!m_cas) == e, "R3 CAS low at RAS fall", int'(!m_cas), int'(e));
                    if (e) check(!prev_cas, "R3 CAS leads RAS", int'(!prev_cas), 1);
                end
                low_len = 0;
            end
            if (!m_ras) low_len++;
            if (!prev_ras && m_ras) begin
                last_low_len  = low_len;
                last_rise_cyc = cyc;
                check(m_cas, "R3 CAS released with RAS", int'(m_cas), 1);
            end
            prev_ras = m_ras;
            prev_cas = m_cas;
        end
    end

    // monitor for the row-address instance
    always begin
        @(posedge clk);
        #2;
        if (rst_n) begin
            if (rprev_ras && !r_ras) begin
                r_fall_cnt++;
                if (rq.size() != 0) begin
                    exp_t e;
                    e = rq.pop_front();
                    check((!r_cas) == e.cbr, "R9 CAS mode at RAS fall", int'(!r_cas), int'(e.cbr));
                    if (!e.cbr) begin
                        check(int'(r_row) == e.row, "R9 row address", int'(r_row), e.row);
                        check(r_rdrv, "R9 row drive", int'(r_rdrv), 1);
                    end
                end
            end
            rprev_ras = r_ras;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int rel, base, rise;
        rst_n = 1'b0;
        grant = 1'b0;
        sleep = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(m_ras == 1'b1, "R10 RAS high in reset", int'(m_ras), 1);
        check(m_cas == 1'b1, "R10 CAS high in reset", int'(m_cas), 1);
        check(m_req == 1'b0, "R10 req low in reset", int'(m_req), 0);
        check(m_busy == 1'b0, "R10 busy low in reset", int'(m_busy), 0);
        check(m_init == 1'b0, "R10 init_done low in reset", int'(m_init), 0);

        push_main(WARM);
        for (int i = 0; i < WARM; i++) rq.push_back('{cbr: 1'b1, row: 0});
        for (int i = 0; i < 5; i++) rq.push_back('{cbr: 1'b0, row: i});
        rel = cyc;
        rst_n = 1'b1;

        // R1 / R2: pause, then warm-up with grant held low
        while (!m_init) @(negedge clk);
        check(first_cas_cyc - rel >= PAUSE, "R1 power-up pause", first_cas_cyc - rel, PAUSE);
        check(fall_cnt == WARM, "R2 warm-up cycle count", fall_cnt, WARM);
        check(!req_pre_init, "R2 no request before init", int'(req_pre_init), 0);

        // R4: periodic spacing with the grant held
        grant = 1'b1;
        push_main(3);
        wait_falls(3);
        check(fall_t[9] - fall_t[8] == INTERVAL, "R4 refresh interval", fall_t[9] - fall_t[8], INTERVAL);
        check(fall_t[10] - fall_t[9] == INTERVAL, "R4 refresh interval", fall_t[10] - fall_t[9], INTERVAL);

        // R5 / R6: withhold the grant for four ticks
        grant = 1'b0;
        while (m_req) @(negedge clk);
        check(m_busy == 1'b0, "R5 busy low after cycle", int'(m_busy), 0);
        while (!m_req) @(negedge clk);
        base = fall_cnt;
        repeat (3 * INTERVAL + 10) @(negedge clk);
        check(fall_cnt == base, "R5 no cycle without grant", fall_cnt - base, 0);
        check(m_req == 1'b1, "R5 request held", int'(m_req), 1);
        check(m_busy == 1'b0, "R5 not busy while waiting", int'(m_busy), 0);
        push_main(BACKLOG);
        grant = 1'b1;
        repeat (40) @(negedge clk);
        check(fall_cnt - base == BACKLOG, "R6 backlog saturates", fall_cnt - base, BACKLOG);
        check(fall_t[base + 1] - fall_t[base] == CSR + RASC + RP, "R6 back-to-back spacing",
              fall_t[base + 1] - fall_t[base], CSR + RASC + RP);
        check(fall_t[base + 2] - fall_t[base + 1] == CSR + RASC + RP, "R6 back-to-back spacing",
              fall_t[base + 2] - fall_t[base + 1], CSR + RASC + RP);
        check(m_req == 1'b0, "R5 request dropped after burst", int'(m_req), 0);

        // R7 / R8: self-refresh with early release of sleep
        sleep = 1'b1;
        push_main(1);
        wait_falls(1);
        check(m_self == 1'b1, "R7 self-refresh active", int'(m_self), 1);
        repeat (10) @(negedge clk);
        sleep = 1'b0;
        while (!m_ras) @(negedge clk);
        check(last_low_len >= SELFMIN, "R7 minimum self-refresh RAS low", last_low_len, SELFMIN);
        check(m_self == 1'b0, "R8 self-refresh left", int'(m_self), 0);
        rise = last_rise_cyc;
        push_main(1);
        wait_falls(1);
        check(fall_t[fall_cnt - 1] - rise >= SEXIT, "R8 exit recovery",
              fall_t[fall_cnt - 1] - rise, SEXIT);
        check(fall_t[fall_cnt - 1] - rise > INTERVAL, "R8 backlog cleared on exit",
              fall_t[fall_cnt - 1] - rise, INTERVAL + 1);

        repeat (20) @(negedge clk);
        check(!we_low, "R3 WE held high", int'(we_low), 0);
        check(mq.size() == 0, "R5 all expected cycles seen", mq.size(), 0);
        check(rq.size() == 0, "R9 row-mode cycles seen", rq.size(), 0);
        check(r_fall_cnt >= WARM + 5, "R9 row-mode cycle count", r_fall_cnt, WARM + 5);
        finished = 1;
        summary();
        $finish;
    end
endmodule